// File: doc/BRIEF.md
# Constant On-Time Switching Sequencer

This block is the digital core of a constant on-time step-down modulator. It has no switching clock of its own. A switching cycle opens only when three things are true together: the regulation comparator asks for energy, the valley current sensed on the low-side switch is under its limit, and the minimum off interval has run out. Each cycle turns the high-side switch on for a fixed number of clock cycles. That count is supplied from outside on every cycle. The high side then turns off and, after a dead interval, the low-side switch turns on.

How the low-side switch behaves depends on the conduction mode. In light-load (diode-emulating) mode, the low side opens as soon as the inductor current reaches zero. Switching then slows down on its own while the on-time stays the same. In continuous mode, the low side stays closed until the next cycle, and it also closes by itself whenever the output sits above target. This lets the output be pulled down after a setpoint step. A negative-current trip opens the low side only in continuous mode. A supervisor can force continuous mode, or hold both switches open through a halt input.

Top module: `ctos_seq`

## Requirements
- R1: While the synchronous active-high reset `rst` is asserted, and in the cycle after it is released, both gate enables are low whatever the sense inputs are.
- R2: Each high-side pulse lasts exactly `ton_cyc` clock cycles, latched when the pulse begins. A value of 0 gives a 1-cycle pulse.
- R3: Between the high side turning off and the low side turning on, both enables are low for exactly `DT_CYC` cycles. The same holds between the low side turning off and the high side turning on.
- R4: The high side stays low for at least `MINOFF_CYC` cycles between pulses. With `demand` held high, `valley_hi` low and continuous mode, the low interval is exactly `MINOFF_CYC + DT_CYC` cycles.
- R5: While `valley_hi` is 1, no new high-side pulse starts. Once it returns to 0 with `demand` high, a pulse follows.
- R6: While `demand` is 0, no new high-side pulse starts.
- R7: Light-load mode is in force when `dem_mode`=1 and `force_pwm`=0. In this mode the low side turns off in the cycle after `zero_cross`=1 is seen, and it stays off while `demand` is 0.
- R8: In continuous mode (`dem_mode`=0), `zero_cross` has no effect: the low side stays on until the next pulse begins.
- R9: `force_pwm`=1 selects continuous mode even when `dem_mode`=1.
- R10: In continuous mode, `neg_trip`=1 turns the low side off in the next cycle. Once `neg_trip` clears with `demand` still 0, the low side comes back on after `DT_CYC` cycles. In light-load mode, `neg_trip` is ignored.
- R11: In continuous mode with both switches off and `demand`=0 (output above target), the low side turns on after `DT_CYC` cycles and stays on until a pulse is due.
- R12: While `halt` is 1, both enables are low in that same cycle. After `halt` falls, the sequence restarts from the idle state.
- R13: `hs_en` and `ls_en` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| demand | input | 1 | Regulation comparator: output below target |
| valley_hi | input | 1 | Low-side current above the valley limit |
| zero_cross | input | 1 | Inductor current has reached zero |
| neg_trip | input | 1 | Negative current limit reached |
| dem_mode | input | 1 | 1 selects light-load diode-emulating mode |
| force_pwm | input | 1 | Supervisor request for continuous mode |
| halt | input | 1 | Disable or fault: hold both switches off |
| ton_cyc | input | TON_W | On-time length in clock cycles |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |

## Verification
The bench builds the block with `DT_CYC`=3, `MINOFF_CYC`=12 and `TON_W`=6. These small values keep each switching cycle to a few dozen clocks, so many pulses fit into a short run. They also let the bench count every dead-time and off-interval length exactly. With `TON_W`=6, the on-time sweep reaches both ends, zero and the all-ones value 63. The mode, negative-trip and halt sequences are each reached within tens of cycles after a pulse.

// File: rtl/ctos_pkg.sv
package ctos_pkg;

    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_GAP_LH  = 3'd1,
        PH_HIGH    = 3'd2,
        PH_GAP_HL  = 3'd3,
        PH_LOW     = 3'd4,
        PH_NEG_OFF = 3'd5
    } phase_e;

    typedef struct packed {
        logic demand;
        logic valley_hi;
        logic zero_cross;
        logic neg_trip;
    } sense_t;

    typedef struct packed {
        logic dem_mode;
        logic force_pwm;
    } mode_t;

    function automatic logic is_continuous(mode_t m);
        return !m.dem_mode || m.force_pwm;
    endfunction

endpackage

// File: rtl/ctos_timer.sv
module ctos_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] len,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= len;
        else if (cnt != '0)
            cnt <= cnt - W'(1);
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/ctos_ctrl.sv
module ctos_ctrl
    import ctos_pkg::*;
#(
    parameter int PH_W = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  sense_t          sense,
    input  mode_t           mode,
    input  logic            halt,
    input  logic            ph_done,
    input  logic            off_done,
    input  logic [PH_W-1:0] dt_len,
    input  logic [PH_W-1:0] ton_len,
    output phase_e          phase,
    output logic            ph_load,
    output logic [PH_W-1:0] ph_len,
    output logic            off_load
);
    phase_e nxt;
    logic   ccm;
    logic   start_ok;

    assign ccm      = is_continuous(mode);
    assign start_ok = sense.demand && !sense.valley_hi && off_done;

    always_comb begin
        nxt      = phase;
        ph_load  = 1'b0;
        ph_len   = dt_len;
        off_load = 1'b0;
        case (phase)
            PH_IDLE: begin
                if (start_ok) begin
                    nxt = PH_GAP_LH; ph_load = 1'b1;
                end else if (ccm && !sense.demand) begin
                    nxt = PH_GAP_HL; ph_load = 1'b1;
                end
            end
            PH_GAP_LH: begin
                if (ph_done) begin
                    nxt = PH_HIGH; ph_load = 1'b1; ph_len = ton_len;
                end
            end
            PH_HIGH: begin
                if (ph_done) begin
                    nxt = PH_GAP_HL; ph_load = 1'b1; off_load = 1'b1;
                end
            end
            PH_GAP_HL: begin
                if (ph_done) nxt = PH_LOW;
            end
            PH_LOW: begin
                if (start_ok) begin
                    nxt = PH_GAP_LH; ph_load = 1'b1;
                end else if (!ccm && sense.zero_cross) begin
                    nxt = PH_IDLE;
                end else if (ccm && sense.neg_trip) begin
                    nxt = PH_NEG_OFF;
                end
            end
            PH_NEG_OFF: begin
                if (start_ok) begin
                    nxt = PH_GAP_LH; ph_load = 1'b1;
                end else if (!ccm) begin
                    nxt = PH_IDLE;
                end else if (!sense.neg_trip && !sense.demand) begin
                    nxt = PH_GAP_HL; ph_load = 1'b1;
                end
            end
            default: nxt = PH_IDLE;
        endcase
        if (halt) begin
            nxt      = PH_IDLE;
            ph_load  = 1'b0;
            off_load = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_IDLE;
        else     phase <= nxt;
    end
endmodule

// File: rtl/ctos_seq.sv
module ctos_seq
    import ctos_pkg::*;
#(
    parameter int DT_CYC     = 4,
    parameter int MINOFF_CYC = 50,
    parameter int TON_W      = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             demand,
    input  logic             valley_hi,
    input  logic             zero_cross,
    input  logic             neg_trip,
    input  logic             dem_mode,
    input  logic             force_pwm,
    input  logic             halt,
    input  logic [TON_W-1:0] ton_cyc,
    output logic             hs_en,
    output logic             ls_en
);
    localparam int DT_W  = $clog2(DT_CYC + 1);
    localparam int PH_W  = (TON_W > DT_W) ? TON_W : DT_W;
    localparam int OFF_W = $clog2(MINOFF_CYC + 1);

    sense_t          sense;
    mode_t           mode;
    phase_e          phase;
    logic            ph_load, ph_done, off_load, off_done;
    logic [PH_W-1:0] ph_len, dt_len, ton_len;

    assign sense   = '{demand: demand, valley_hi: valley_hi,
                       zero_cross: zero_cross, neg_trip: neg_trip};
    assign mode    = '{dem_mode: dem_mode, force_pwm: force_pwm};
    assign dt_len  = PH_W'(DT_CYC - 1);
    assign ton_len = (ton_cyc == '0) ? '0 : PH_W'(ton_cyc - TON_W'(1));

    ctos_ctrl #(.PH_W(PH_W)) u_ctrl (
        .clk(clk), .rst(rst), .sense(sense), .mode(mode), .halt(halt),
        .ph_done(ph_done), .off_done(off_done), .dt_len(dt_len),
        .ton_len(ton_len), .phase(phase), .ph_load(ph_load),
        .ph_len(ph_len), .off_load(off_load)
    );

    ctos_timer #(.W(PH_W)) u_phase_tmr (
        .clk(clk), .rst(rst), .load(ph_load), .len(ph_len), .done(ph_done)
    );

    ctos_timer #(.W(OFF_W)) u_off_tmr (
        .clk(clk), .rst(rst), .load(off_load),
        .len(OFF_W'(MINOFF_CYC - 1)), .done(off_done)
    );

    assign hs_en = (phase == PH_HIGH) && !halt;
    assign ls_en = (phase == PH_LOW)  && !halt;
endmodule

// File: rtl/ctos_seq_chk.sv
module ctos_seq_chk #(
    parameter int MINOFF_CYC = 50
) (
    input logic clk,
    input logic rst,
    input logic hs_en,
    input logic ls_en,
    input logic halt,
    input logic dem_mode,
    input logic force_pwm,
    input logic zero_cross
);
    int unsigned off_run;

    always_ff @(posedge clk) begin
        if (rst)        off_run <= MINOFF_CYC;
        else if (hs_en) off_run <= 0;
        else if (off_run < MINOFF_CYC) off_run <= off_run + 1;
    end

    a_r13_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(hs_en && ls_en));
    a_r3_gap_before_high: assert property (@(posedge clk) disable iff (rst)
        $rose(hs_en) |-> $past(!ls_en));
    a_r3_gap_before_low: assert property (@(posedge clk) disable iff (rst)
        $rose(ls_en) |-> $past(!hs_en));
    a_r4_min_off: assert property (@(posedge clk) disable iff (rst)
        $rose(hs_en) |-> off_run >= MINOFF_CYC);
    a_r7_light_load_release: assert property (@(posedge clk) disable iff (rst)
        (ls_en && dem_mode && !force_pwm && zero_cross) |=> !ls_en);
    a_r12_halt_quiet: assert property (@(posedge clk) disable iff (rst)
        halt |-> (!hs_en && !ls_en));
    a_r12_restart_idle: assert property (@(posedge clk) disable iff (rst)
        $fell(halt) |-> !hs_en);
endmodule

bind ctos_seq ctos_seq_chk #(.MINOFF_CYC(MINOFF_CYC)) u_chk (
    .clk(clk), .rst(rst), .hs_en(hs_en), .ls_en(ls_en), .halt(halt),
    .dem_mode(dem_mode), .force_pwm(force_pwm), .zero_cross(zero_cross)
);

// File: tb/ctos_seq_bench.sv
`timescale 1ns/1ps
module ctos_seq_bench;
    localparam int DT  = 3;
    localparam int MO  = 12;
    localparam int TW  = 6;
    localparam int NV  = 5;
    localparam int unsigned VEC [NV][2] = '{'{5, 5}, '{1, 1}, '{0, 1}, '{17, 17}, '{63, 63}};

    logic clk = 1'b0;
    logic rst, demand, valley_hi, zero_cross, neg_trip, dem_mode, force_pwm, halt;
    logic [TW-1:0] ton_cyc;
    logic hs_en, ls_en;

    int total = 0;
    int bad   = 0;

    ctos_seq #(.DT_CYC(DT), .MINOFF_CYC(MO), .TON_W(TW)) u_ctos_seq (
        .clk(clk), .rst(rst), .demand(demand), .valley_hi(valley_hi),
        .zero_cross(zero_cross), .neg_trip(neg_trip), .dem_mode(dem_mode),
        .force_pwm(force_pwm), .halt(halt), .ton_cyc(ton_cyc),
        .hs_en(hs_en), .ls_en(ls_en)
    );

    always #4 clk = ~clk;

    // port monitor, sampled on the falling edge
    logic hs_q = 1'b0, ls_q = 1'b0;
    int hs_hi = 0, hs_lo = 1000, ls_lo = 1000;
    int pulses = 0, overlap = 0, width = 0, off_len = 0, gap_lh = 0, gap_hl = 0;

    always @(negedge clk) begin
        hs_q <= hs_en;
        ls_q <= ls_en;
        if (hs_en && ls_en) overlap <= overlap + 1;
        if (hs_en && !hs_q) begin
            pulses  <= pulses + 1;
            off_len <= hs_lo;
            gap_lh  <= ls_lo;
        end
        if (!hs_en && hs_q) width <= hs_hi;
        if (ls_en && !ls_q) gap_hl <= hs_lo;
        hs_hi <= hs_en ? hs_hi + 1 : 0;
        hs_lo <= hs_en ? 0 : hs_lo + 1;
        ls_lo <= ls_en ? 0 : ls_lo + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wait_rise(input int p, input int lim, input string req);
        int k = 0;
        while (pulses <= p && k < lim) begin
            tick(1);
            k++;
        end
        chk(pulses > p, req, pulses, p + 1);
    endtask

    initial begin
        #(8 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int p;
        rst = 1'b1; demand = 1'b1; valley_hi = 1'b0; zero_cross = 1'b0;
        neg_trip = 1'b0; dem_mode = 1'b1; force_pwm = 1'b0; halt = 1'b0;
        ton_cyc = 6'd5;
        tick(4);
        chk(!hs_en && !ls_en, "R1 in reset", {hs_en, ls_en}, 0);
        demand = 1'b0;
        rst = 1'b0;
        tick(1);
        chk(!hs_en && !ls_en, "R1 after reset", {hs_en, ls_en}, 0);

        // table sweep of on-time, continuous mode
        dem_mode = 1'b0;
        for (int i = 0; i < NV; i++) begin
            demand = 1'b0;
            tick(30);
            ton_cyc = TW'(VEC[i][0]);
            p = pulses;
            demand = 1'b1;
            wait_rise(p, 40, "R6 pulse on demand");
            demand = 1'b0;
            tick(100);
            chk(width == int'(VEC[i][1]), "R2 on-time width", width, int'(VEC[i][1]));
            chk(pulses == p + 1, "R6 single pulse", pulses, p + 1);
            chk(gap_hl == DT, "R3 high-to-low gap", gap_hl, DT);
            chk(gap_lh == DT, "R3 low-to-high gap", gap_lh, DT);
        end

        // R4: steady demand, minimum off interval
        ton_cyc = 6'd5;
        p = pulses;
        demand = 1'b1;
        for (int k = 0; k < 200 && pulses < p + 3; k++) tick(1);
        chk(pulses >= p + 3, "R4 repeated pulses", pulses, p + 3);
        chk(off_len == MO + DT, "R4 off interval", off_len, MO + DT);
        demand = 1'b0;
        tick(60);

        // R5: valley limit blocks a start
        p = pulses;
        valley_hi = 1'b1;
        demand = 1'b1;
        tick(40);
        chk(pulses == p, "R5 blocked by valley", pulses, p);
        chk(ls_en == 1'b1, "R5 low side held", ls_en, 1);
        valley_hi = 1'b0;
        wait_rise(p, 20, "R5 start after release");
        demand = 1'b0;
        tick(100);

        // R7 / R6: light-load mode
        dem_mode = 1'b1;
        p = pulses;
        demand = 1'b1;
        wait_rise(p, 40, "R7 pulse");
        demand = 1'b0;
        tick(5 + DT + 3);
        chk(ls_en == 1'b1, "R7 low side on after pulse", ls_en, 1);
        tick(10);
        chk(ls_en == 1'b1, "R7 low side held before zero", ls_en, 1);
        zero_cross = 1'b1;
        tick(1);
        chk(ls_en == 1'b0, "R7 release on zero cross", ls_en, 0);
        zero_cross = 1'b0;
        tick(20);
        chk(!ls_en && !hs_en, "R7 idle at light load", {hs_en, ls_en}, 0);
        chk(pulses == p + 1, "R6 no pulse without demand", pulses, p + 1);

        // R11 / R8: continuous mode pulls down, zero cross ignored
        dem_mode = 1'b0;
        tick(DT + 2);
        chk(ls_en == 1'b1, "R11 low side on above target", ls_en, 1);
        zero_cross = 1'b1;
        tick(10);
        chk(ls_en == 1'b1, "R8 zero cross ignored", ls_en, 1);

        // R9: forced continuous overrides light-load
        dem_mode = 1'b1;
        force_pwm = 1'b1;
        tick(10);
        chk(ls_en == 1'b1, "R9 force keeps low side", ls_en, 1);
        force_pwm = 1'b0;
        tick(1);
        chk(ls_en == 1'b0, "R9 release when force drops", ls_en, 0);
        zero_cross = 1'b0;

        // R10: negative current trip
        dem_mode = 1'b0;
        tick(DT + 3);
        chk(ls_en == 1'b1, "R10 low side on", ls_en, 1);
        neg_trip = 1'b1;
        tick(1);
        chk(ls_en == 1'b0, "R10 trip opens low side", ls_en, 0);
        tick(5);
        chk(ls_en == 1'b0, "R10 held open", ls_en, 0);
        neg_trip = 1'b0;
        tick(DT + 2);
        chk(ls_en == 1'b1, "R10 low side back on", ls_en, 1);
        dem_mode = 1'b1;
        neg_trip = 1'b1;
        tick(6);
        chk(ls_en == 1'b1, "R10 trip ignored at light load", ls_en, 1);
        neg_trip = 1'b0;
        zero_cross = 1'b1;
        tick(1);
        chk(ls_en == 1'b0, "R7 zero cross release", ls_en, 0);
        zero_cross = 1'b0;
        dem_mode = 1'b0;

        // R12: halt
        ton_cyc = 6'd63;
        tick(DT + 3);
        p = pulses;
        demand = 1'b1;
        wait_rise(p, 40, "R12 pulse before halt");
        tick(2);
        halt = 1'b1;
        #1;
        chk(!hs_en && !ls_en, "R12 halt same cycle", {hs_en, ls_en}, 0);
        p = pulses;
        tick(20);
        chk(!hs_en && !ls_en, "R12 held during halt", {hs_en, ls_en}, 0);
        chk(pulses == p, "R12 no pulse during halt", pulses, p);
        halt = 1'b0;
        wait_rise(p, 40, "R12 restart after halt");
        demand = 1'b0;
        tick(100);

        chk(overlap == 0, "R13 no overlap", overlap, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule